// File: doc/BRIEF.md
# MDIO Management Slave Responder

This block plays the PHY side of a management data bus whose clock and data lines a host drives purely in software. The host writes a 4-bit control word: data-out, output-enable and clock. It reads back the same word, which also carries the data-in bit that this block drives. Every control write that takes the clock bit from low to high is one bus clock. On that clock the block samples the line, watches for the preamble and decodes the 16-bit header. It then either shifts 16 bits of read data out on data-in or takes in 16 bits of write data.

The readable side is a 32-entry by 16-bit PHY register file. Every entry reads as zero except the two identifier entries. Write transactions are decoded and take the full frame, but the data is dropped, so the file always holds its reset values. The PHY address field is decoded but never compared, so the block answers at any address.

Top module: `mdio_mgmt_responder`

## Requirements
- R1: After reset the control word reads 0. The cycle after a host write, bits 0 (data-out), 2 (output-enable) and 3 (clock) read back the written values.
- R2: Bit 1 (data-in) cannot be written by the host. A host write leaves it unchanged unless that same write is a bus clock in the read-data phase.
- R3: A bus clock is a host write with bit 3 set whose previous host write had bit 3 clear. The bit sampled on that clock is 1 only when data-out and output-enable are both set. Repeated writes with the clock held high are not bus clocks.
- R4: The block synchronises only after 32 consecutive sampled ones, and a longer run of ones keeps it synchronised. The next 16 sampled bits form the header. A run of 31 ones, or ones driven with output-enable clear, gives no sync.
- R5: The header is sampled MSB first as start [15:14], opcode [13:12], PHY address [11:7], register address [6:2] and turnaround [1:0]. Start 01 with opcode 10 and turnaround bit 0 clear selects a read. The PHY address has no effect.
- R6: On a read, the 16 bus clocks after the header each place one bit of the addressed register on data-in, MSB first. Each bit is visible the cycle after the clock write.
- R7: A header with a start code other than 01, an opcode other than 01 or 10, or a read turnaround with bit 0 set leaves the block idle, and data-in is not driven during the 16 bits that follow.
- R8: Start 01 with opcode 01 and turnaround 10 selects a write. The block takes 16 data bits and discards them, so a later read of the same register returns its reset value, and data-in is not driven.
- R9: Register 2 reads as 0x0022 and register 3 as 0x161A. Every other register reads as 0.
- R10: Once a transaction has used its 16 data bits, the block ignores further headers until a new preamble arrives.
- R11: Data-in changes only on bus clocks in the read-data phase. It holds through the low-clock writes and after the last data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Host write strobe for the control word |
| ctl_wdata | input | 4 | Control word written by the host: {clock, output-enable, ignored, data-out} |
| ctl_rdata | output | 4 | Control word as read by the host: {clock, output-enable, data-in, data-out} |

## Verification
Reads of the two identifier registers, which hold mixed bit patterns, and of zero registers at the edges of the address range, each at a different PHY address, show that the addressing is right, that the bit order is MSB first, and that the PHY address is ignored. Headers with a bad start code, a bad opcode or a bad turnaround are sent while they address register 3, so any wrongly accepted read would drive a one onto data-in. Short preambles, preambles with output-enable clear, and headers sent without any preamble separate real sync from a leftover countdown. Doubled high-clock writes show that only low-to-high writes count as clocks. A write to an identifier register followed by a read of it shows that write data is discarded, and a low-clock write in the middle of a read shows that the host cannot overwrite data-in.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Control word bit positions (host visible)
  localparam int CTL_DOUT = 0;
  localparam int CTL_DIN  = 1;
  localparam int CTL_OE   = 2;
  localparam int CTL_CLK  = 3;
  localparam int CTL_W    = 4;

  // Header field codes
  localparam logic [1:0] HDR_START = 2'b01;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] TA_WRITE  = 2'b10;

  // PHY address field width (fixed by the frame format)
  localparam int PHY_AW = 5;

  typedef enum logic [1:0] {
    XFER_IDLE  = 2'd0,
    XFER_READ  = 2'd1,
    XFER_WRITE = 2'd2
  } xfer_e;

endpackage

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int HIST_W = 32,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_rise,
  input  logic              bit_in,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              shift_en
);

  localparam int CNT_W    = $clog2(HIST_W) + 2;
  localparam int REG_LSB  = 2;
  localparam int PHY_LSB  = REG_LSB + ADDR_W;
  localparam int OP_LSB   = PHY_LSB + PHY_AW;
  localparam int ST_LSB   = OP_LSB + 2;

  localparam logic signed [CNT_W-1:0] CNT_IDLE = -1;
  localparam logic signed [CNT_W-1:0] CNT_SYNC = CNT_W'(HIST_W);
  localparam logic signed [CNT_W-1:0] CNT_HDR  = CNT_W'(DATA_W);
  localparam logic signed [CNT_W-1:0] CNT_LAST = '0;

  logic [HIST_W-2:0]       hist_q;
  logic [HIST_W-1:0]       hist_n;
  logic [DATA_W-1:0]       hdr;
  logic signed [CNT_W-1:0] cnt_q;
  logic signed [CNT_W-1:0] cnt_sel;
  xfer_e                   state_q;
  logic                    sync_hit;
  logic                    hdr_now;
  logic                    is_rd;
  logic                    is_wr;

  assign hist_n   = {hist_q, bit_in};
  assign sync_hit = &hist_n;
  assign cnt_sel  = sync_hit ? CNT_SYNC : cnt_q;
  assign hdr      = hist_n[DATA_W-1:0];
  assign hdr_now  = clk_rise && (cnt_sel == CNT_HDR);

  assign is_rd = (hdr[ST_LSB+1:ST_LSB] == HDR_START) &&
                 (hdr[OP_LSB+1:OP_LSB] == OP_READ) && !hdr[0];
  assign is_wr = (hdr[ST_LSB+1:ST_LSB] == HDR_START) &&
                 (hdr[OP_LSB+1:OP_LSB] == OP_WRITE) && (hdr[1:0] == TA_WRITE);

  assign rd_req   = hdr_now && is_rd;
  assign rd_addr  = hdr[REG_LSB+ADDR_W-1:REG_LSB];
  assign shift_en = clk_rise && (state_q == XFER_READ) && (cnt_sel < CNT_HDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= '0;
      cnt_q   <= CNT_IDLE;
      state_q <= XFER_IDLE;
    end else if (clk_rise) begin
      hist_q <= hist_n[HIST_W-2:0];
      cnt_q  <= (cnt_sel == CNT_IDLE) ? CNT_IDLE : cnt_sel - 1'b1;
      if (hdr_now) begin
        if (is_wr)      state_q <= XFER_WRITE;
        else if (is_rd) state_q <= XFER_READ;
        else            state_q <= XFER_IDLE;
      end else if (cnt_sel == CNT_LAST) begin
        // write data (low bits of history) is accepted and dropped here
        state_q <= XFER_IDLE;
      end
    end
  end

endmodule

// File: rtl/mdio_phy_regfile.sv
module mdio_phy_regfile #(
  parameter int             DEPTH     = 32,
  parameter int             DATA_W    = 16,
  parameter int             ID_HI_IDX = 2,
  parameter logic [15:0]    ID_HI_VAL = 16'h0022,
  parameter int             ID_LO_IDX = 3,
  parameter logic [15:0]    ID_LO_VAL = 16'h161A,
  localparam int            ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  function automatic logic [DATA_W-1:0] entry_value(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(ID_HI_IDX)) return DATA_W'(ID_HI_VAL);
    if (a == ADDR_W'(ID_LO_IDX)) return DATA_W'(ID_LO_VAL);
    return '0;
  endfunction

  // Read-only contents with a registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= entry_value(rd_addr);
    end
  end

endmodule

// File: rtl/mdio_mgmt_responder.sv
module mdio_mgmt_responder
  import mdio_pkg::*;
#(
  parameter int HIST_W    = 32,
  parameter int DATA_W    = 16,
  parameter int REG_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_we,
  input  logic [3:0]  ctl_wdata,
  output logic [3:0]  ctl_rdata
);

  localparam int ADDR_W = $clog2(REG_DEPTH);

  logic [CTL_W-1:0]  ctl_q;
  logic              prev_clk_q;
  logic [DATA_W-1:0] shift_q;
  logic              clk_rise;
  logic              bit_in;
  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic              shift_en;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;
  logic              unused_din_wr;

  assign unused_din_wr = ctl_wdata[CTL_DIN];
  assign clk_rise = ctl_we && !prev_clk_q && ctl_wdata[CTL_CLK];
  assign bit_in   = ctl_wdata[CTL_DOUT] && ctl_wdata[CTL_OE];
  assign ctl_rdata = ctl_q;

  mdio_frame_ctrl #(
    .HIST_W (HIST_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .clk_rise (clk_rise),
    .bit_in   (bit_in),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .shift_en (shift_en)
  );

  mdio_phy_regfile #(
    .DEPTH  (REG_DEPTH),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_req),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      prev_clk_q <= 1'b0;
      shift_q    <= '0;
    end else begin
      if (ctl_we) begin
        ctl_q[CTL_DOUT] <= ctl_wdata[CTL_DOUT];
        ctl_q[CTL_OE]   <= ctl_wdata[CTL_OE];
        ctl_q[CTL_CLK]  <= ctl_wdata[CTL_CLK];
        prev_clk_q      <= ctl_wdata[CTL_CLK];
      end
      if (rd_valid) begin
        shift_q <= rd_data;
      end else if (shift_en) begin
        ctl_q[CTL_DIN] <= shift_q[DATA_W-1];
        shift_q        <= {shift_q[DATA_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/mdio_mgmt_responder_sva.sv
module mdio_mgmt_responder_sva #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_we,
  input logic [3:0]        ctl_wdata,
  input logic [3:0]        ctl_rdata,
  input logic              clk_rise,
  input logic              shift_en,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] shift_q
);

  assert_ctl_echo_R1: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (ctl_rdata[3:2] == $past(ctl_wdata[3:2])) &&
               (ctl_rdata[0] == $past(ctl_wdata[0])));

  assert_din_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(ctl_rdata[1]));

  assert_shift_needs_clock_R3: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> clk_rise);

  assert_hdr_not_data_R5: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !shift_en);

  assert_din_msb_R6: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> ctl_rdata[1] == $past(shift_q[DATA_W-1]));

  assert_id_hi_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_addr) == ADDR_W'(2)) |-> rd_data == DATA_W'(16'h0022));

  assert_id_lo_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_addr) == ADDR_W'(3)) |-> rd_data == DATA_W'(16'h161A));

endmodule

bind mdio_mgmt_responder mdio_mgmt_responder_sva #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_sva (
  .clk       (clk),
  .rst       (rst),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .ctl_rdata (ctl_rdata),
  .clk_rise  (clk_rise),
  .shift_en  (shift_en),
  .rd_req    (rd_req),
  .rd_addr   (rd_addr),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .shift_q   (shift_q)
);

// File: tb/mdio_mgmt_responder_test.sv
`timescale 1ns/1ps
module mdio_mgmt_responder_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_we = 1'b0;
  logic [3:0] ctl_wdata = 4'h0;
  logic [3:0] ctl_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mdio_mgmt_responder uut (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata)
  );

  // Expected register contents (R9)
  function automatic logic [15:0] exp_reg(input logic [4:0] a);
    if (a == 5'd2) return 16'h0022;
    if (a == 5'd3) return 16'h161A;
    return 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] d);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // one bus bit: clock low, clock high (optionally high again, not an edge)
  task automatic drive_bit(input logic b, input logic oe, input bit dbl);
    host_write({1'b0, oe, 1'b0, b});
    host_write({1'b1, oe, 1'b0, b});
    if (dbl) host_write({1'b1, oe, 1'b0, b});
  endtask

  task automatic preamble(input int n, input logic oe);
    for (int i = 0; i < n; i++) drive_bit(1'b1, oe, 1'b0);
  endtask

  task automatic header(input logic [1:0] st, input logic [1:0] op,
                        input logic [4:0] phy, input logic [4:0] ra,
                        input logic [1:0] ta, input logic ta_oe, input bit dbl);
    logic [13:0] h;
    h = {st, op, phy, ra};
    for (int i = 13; i >= 0; i--) drive_bit(h[i], 1'b1, dbl);
    drive_bit(ta[1], ta_oe, dbl);
    drive_bit(ta[0], ta_oe, dbl);
  endtask

  // 16 data clocks with the line released; collects data-in, checks holds
  task automatic read_bits(input int n, input bit dbl, output logic [15:0] w,
                           output bit hold_ok, output bit any_one);
    logic prev;
    w = '0;
    hold_ok = 1'b1;
    any_one = 1'b0;
    prev = ctl_rdata[1];
    for (int i = 0; i < n; i++) begin
      host_write(4'b0000);
      if (ctl_rdata[1] !== prev) hold_ok = 1'b0;
      host_write(4'b1000);
      if (dbl) host_write(4'b1000);
      w = {w[14:0], ctl_rdata[1]};
      if (ctl_rdata[1]) any_one = 1'b1;
      prev = ctl_rdata[1];
    end
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] ra, input bit dbl,
                         output logic [15:0] w, output bit hold_ok);
    bit any;
    preamble(32, 1'b1);
    header(2'b01, 2'b10, phy, ra, 2'b00, 1'b0, dbl);
    read_bits(16, dbl, w, hold_ok, any);
  endtask

  task automatic t_reset;
    check(ctl_rdata == 4'h0, "R1 reset value", ctl_rdata, 4'h0);
  endtask

  task automatic t_ctl_echo;
    host_write(4'b1111);
    check(ctl_rdata == 4'b1101, "R1/R2 echo with din protected", ctl_rdata, 4'b1101);
    host_write(4'b0010);
    check(ctl_rdata == 4'b0000, "R2 din write ignored", ctl_rdata, 4'b0000);
  endtask

  task automatic t_read_ids;
    logic [15:0] w;
    bit hold;
    do_read(5'd1, 5'd2, 1'b0, w, hold);
    check(w == exp_reg(5'd2), "R9/R6 reg2", w, exp_reg(5'd2));
    check(hold, "R11 din holds on low clock", hold, 1);
    do_read(5'd31, 5'd3, 1'b0, w, hold);
    check(w == exp_reg(5'd3), "R9/R5 reg3 any phy", w, exp_reg(5'd3));
    do_read(5'd0, 5'd0, 1'b0, w, hold);
    check(w == 16'h0, "R9 reg0", w, 16'h0);
    do_read(5'd7, 5'd31, 1'b0, w, hold);
    check(w == 16'h0, "R9 reg31", w, 16'h0);
  endtask

  task automatic t_din_protect;
    logic [15:0] w;
    bit hold, any;
    preamble(32, 1'b1);
    header(2'b01, 2'b10, 5'd4, 5'd3, 2'b00, 1'b0, 1'b0);
    read_bits(4, 1'b0, w, hold, any);   // bits 0,0,0,1 of 0x161A
    check(ctl_rdata[1] == 1'b1, "R6 partial read bit", ctl_rdata[1], 1);
    host_write(4'b0010);
    check(ctl_rdata[1] == 1'b1, "R2 host cannot clear din", ctl_rdata[1], 1);
    read_bits(12, 1'b0, w, hold, any);
    check(w[11:0] == 12'h61A, "R6 rest of reg3", w[11:0], 12'h61A);
    host_write(4'b0000);
    host_write(4'b1000);
    check(ctl_rdata[1] == 1'b0, "R11 din holds after last bit", ctl_rdata[1], 0);
  endtask

  task automatic t_write_discard;
    logic [15:0] w, v;
    bit hold;
    v = 16'hBEEF;
    preamble(32, 1'b1);
    header(2'b01, 2'b01, 5'd1, 5'd2, 2'b10, 1'b1, 1'b0);
    for (int i = 15; i >= 0; i--) drive_bit(v[i], 1'b1, 1'b0);
    check(ctl_rdata[1] == 1'b0, "R8 din not driven in write", ctl_rdata[1], 0);
    do_read(5'd1, 5'd2, 1'b0, w, hold);
    check(w == 16'h0022, "R8 reg2 after write", w, 16'h0022);
    preamble(32, 1'b1);
    header(2'b01, 2'b01, 5'd1, 5'd5, 2'b10, 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) drive_bit(1'b1, 1'b1, 1'b0);
    do_read(5'd1, 5'd5, 1'b0, w, hold);
    check(w == 16'h0, "R8 reg5 after write", w, 16'h0);
  endtask

  task automatic bad_hdr(input logic [1:0] st, input logic [1:0] op,
                         input logic [1:0] ta, input logic ta_oe, input string tag);
    logic [15:0] w;
    bit hold, any;
    preamble(32, 1'b1);
    header(st, op, 5'd1, 5'd3, ta, ta_oe, 1'b0);
    read_bits(16, 1'b0, w, hold, any);
    check(!any, tag, w, 16'h0);
  endtask

  task automatic t_bad_headers;
    bad_hdr(2'b00, 2'b10, 2'b00, 1'b0, "R7 bad start");
    bad_hdr(2'b01, 2'b11, 2'b00, 1'b0, "R7 bad opcode");
    bad_hdr(2'b01, 2'b10, 2'b11, 1'b1, "R7 read turnaround bit0 set");
  endtask

  task automatic t_sync;
    logic [15:0] w;
    bit hold, any;
    // no preamble after a finished transaction
    header(2'b01, 2'b10, 5'd1, 5'd3, 2'b00, 1'b0, 1'b0);
    read_bits(16, 1'b0, w, hold, any);
    check(!any, "R10 header without preamble ignored", w, 16'h0);
    preamble(31, 1'b1);
    header(2'b01, 2'b10, 5'd1, 5'd3, 2'b00, 1'b0, 1'b0);
    read_bits(16, 1'b0, w, hold, any);
    check(!any, "R4 31 ones no sync", w, 16'h0);
    preamble(40, 1'b0);
    header(2'b01, 2'b10, 5'd1, 5'd3, 2'b00, 1'b0, 1'b0);
    read_bits(16, 1'b0, w, hold, any);
    check(!any, "R3/R4 ones without oe no sync", w, 16'h0);
    preamble(40, 1'b1);
    header(2'b01, 2'b10, 5'd1, 5'd3, 2'b00, 1'b0, 1'b0);
    read_bits(16, 1'b0, w, hold, any);
    check(w == 16'h161A, "R4 long preamble", w, 16'h161A);
  endtask

  task automatic t_double_clock;
    logic [15:0] w;
    bit hold;
    preamble(32, 1'b1);
    header(2'b01, 2'b10, 5'd2, 5'd3, 2'b00, 1'b0, 1'b1);
    begin
      bit any;
      read_bits(16, 1'b1, w, hold, any);
    end
    check(w == 16'h161A, "R3 held-high write not a clock", w, 16'h161A);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctl_echo();
    t_read_ids();
    t_din_protect();
    t_write_discard();
    t_bad_headers();
    t_sync();
    t_double_clock();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule